// File: doc/BRIEF.md
# Token Session and Gate-Order Controller

This controller sits on the control side of a token that garbles a boolean circuit. A client streams the circuit to the token one record at a time. Each new session takes its identifier from a session counter that never goes backward. Only this counter outlives a reset; every other piece of session state is volatile. The controller checks the order and shape of the stream and decides whether each record is accepted. The wire-garbling, table and MAC datapaths sit outside the block. They see the accepted records, and the controller takes the finished MAC from them.

A session runs in this order: one start command, then one header, then gates, then output records, then a MAC submission. The header gives the number of client input wires (X), server input wires (Y) and output records (Z). Wires below X+Y are inputs. Every gate label must be at least X+Y and strictly above the previous accepted label, so no gate is garbled twice. An output may only name a wire that already exists. The output-decryption key is passed to the key port only after all Z outputs have arrived and the submitted MAC matches the computed one in a constant-time compare. Any violation locks the session until the next start.

Top module: `token_gate_ctrl`

## Requirements
- R1: A start command (op 0) returns ok, and the session identifier becomes the previous counter value plus one in the response cycle. The identifier does not change on any other command.
- R2: The session counter keeps its value across an assertion of rst_n. After reset no session is open, so any non-start command is rejected.
- R3: A gate command (op 2, label on cmd_a) is accepted only if its label is at least X+Y and strictly greater than the last accepted label. An equal or smaller label is rejected.
- R4: After any rejection inside an open session, every command other than start is rejected until the next start.
- R5: An output record (op 3, wire on cmd_a) is rejected if the wire index is at or above the last accepted gate label plus one. Before any gate is accepted, the limit is X+Y.
- R6: A command in the wrong phase is rejected. This covers: any command before a start, a second header (op 1, X on cmd_a, Y on cmd_b, Z on cmd_c), a gate after an output, a (Z+1)th output, a MAC (op 4) before all Z outputs, and op codes 5 to 7.
- R7: When all Z outputs have been taken, a MAC whose value equals mac_calc is accepted. key_valid then rises, and key_out carries key_in until the next start.
- R8: A MAC that differs from mac_calc in any bit is rejected, and key_out stays zero.
- R9: key_out is zero whenever key_valid is low. key_valid is low after reset and after every start.
- R10: Every command gets exactly one response, one cycle later, with rsp_valid high. rsp_valid is low in all other cycles.
- R11: A start issued when the counter is at its maximum value is rejected, and the counter keeps that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of volatile session state |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 start, 1 header, 2 gate, 3 output, 4 MAC |
| cmd_a | input | WIRE_W | X, gate label or output wire |
| cmd_b | input | WIRE_W | Y (header only) |
| cmd_c | input | WIRE_W | Z (header only) |
| cmd_mac | input | MAC_W | Submitted MAC |
| mac_calc | input | MAC_W | MAC computed by the external datapath |
| key_in | input | KEY_W | Output-decryption key from the external datapath |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Command accepted |
| sess_id | output | CTR_W | Current session identifier |
| key_valid | output | 1 | Key released |
| key_out | output | KEY_W | Released key, zero otherwise |

## Verification
The bench drives gate-label sequences that start exactly at X+Y, skip labels, repeat a label, and step backward. These show whether the strict-greater-than compare is off by one. Output records are sent naming the newest wire, an input wire, and the first wire that does not exist yet, which exercises the existence bound. Sessions end with a matching MAC, a MAC that differs in one bit, and a MAC sent too early, so key release can be told apart from lock-out. A mid-session reset followed by a run of starts up to the counter ceiling shows that the counter persists across reset and refuses to wrap.

// File: rtl/token_gate_ctrl.sv
module token_gate_ctrl #(
  parameter int WIRE_W = 12,
  parameter int CTR_W  = 16,
  parameter int MAC_W  = 64,
  parameter int KEY_W  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [WIRE_W-1:0] cmd_a,
  input  logic [WIRE_W-1:0] cmd_b,
  input  logic [WIRE_W-1:0] cmd_c,
  input  logic [MAC_W-1:0]  cmd_mac,
  input  logic [MAC_W-1:0]  mac_calc,
  input  logic [KEY_W-1:0]  key_in,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [CTR_W-1:0]  sess_id,
  output logic              key_valid,
  output logic [KEY_W-1:0]  key_out
);

  localparam logic [2:0] OP_START = 3'd0;
  localparam logic [2:0] OP_HDR   = 3'd1;
  localparam logic [2:0] OP_GATE  = 3'd2;
  localparam logic [2:0] OP_OUT   = 3'd3;
  localparam logic [2:0] OP_MAC   = 3'd4;
  localparam int IDX_W = WIRE_W + 1;

  typedef enum logic [2:0] {PH_IDLE, PH_HDR, PH_BODY, PH_DONE, PH_ERR} phase_t;

  logic [CTR_W-1:0]  sess_ctr = '0;
  phase_t            phase, phase_nx;
  logic [IDX_W-1:0]  gmin;
  logic [WIRE_W-1:0] out_left;
  logic              out_seen;
  logic              rel;
  logic              good;

  wire              is_start = cmd_op == OP_START;
  wire              ctr_full = &sess_ctr;
  wire [IDX_W-1:0]  arg_a    = {1'b0, cmd_a};
  wire              in_body  = phase == PH_BODY;
  wire [MAC_W-1:0]  mac_diff = cmd_mac ^ mac_calc;
  wire              mac_eq   = ~|mac_diff;

  wire start_ok = !ctr_full;
  wire hdr_ok   = phase == PH_HDR;
  wire gate_ok  = in_body && !out_seen && (arg_a >= gmin);
  wire out_ok   = in_body && (out_left != '0) && (arg_a < gmin);
  wire mac_ok   = in_body && (out_left == '0) && mac_eq;

  always_comb begin
    case (cmd_op)
      OP_START: good = start_ok;
      OP_HDR:   good = hdr_ok;
      OP_GATE:  good = gate_ok;
      OP_OUT:   good = out_ok;
      OP_MAC:   good = mac_ok;
      default:  good = 1'b0;
    endcase
  end

  always_comb begin
    phase_nx = phase;
    if (cmd_valid) begin
      if (is_start)
        phase_nx = start_ok ? PH_HDR : PH_ERR;
      else if (good) begin
        if (cmd_op == OP_HDR) phase_nx = PH_BODY;
        else if (cmd_op == OP_MAC) phase_nx = PH_DONE;
      end else if (phase == PH_HDR || phase == PH_BODY)
        phase_nx = PH_ERR;
    end
  end

  always_ff @(posedge clk)
    if (rst_n && cmd_valid && is_start && start_ok)
      sess_ctr <= sess_ctr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      gmin      <= '0;
      out_left  <= '0;
      out_seen  <= 1'b0;
      rel       <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
    end else begin
      phase     <= phase_nx;
      rsp_valid <= cmd_valid;
      rsp_ok    <= cmd_valid && good;
      if (cmd_valid) begin
        if (is_start) rel <= 1'b0;
        if (good) begin
          case (cmd_op)
            OP_HDR: begin
              gmin     <= {1'b0, cmd_a} + {1'b0, cmd_b};
              out_left <= cmd_c;
              out_seen <= 1'b0;
            end
            OP_GATE: gmin <= arg_a + 1'b1;
            OP_OUT: begin
              out_left <= out_left - 1'b1;
              out_seen <= 1'b1;
            end
            OP_MAC:  rel <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  assign sess_id   = sess_ctr;
  assign key_valid = rel;
  assign key_out   = rel ? key_in : '0;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid); // R10
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid); // R10
  AST_SID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok && $past(cmd_op) == OP_START) |-> sess_id == CTR_W'($past(sess_id) + 1'b1)); // R1
  AST_SID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && is_start) |=> $stable(sess_id)); // R1
  AST_ERR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ERR && cmd_valid && !is_start) |=> (rsp_valid && !rsp_ok)); // R4
  AST_KEY_AFTER_MAC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_valid) |-> $past(cmd_valid && cmd_op == OP_MAC)); // R7
  AST_KEY_CLR_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_start) |=> !key_valid); // R9

endmodule

// File: tb/token_gate_ctrl_tb.sv
module token_gate_ctrl_tb;
  localparam int WIRE_W = 8, CTR_W = 4, MAC_W = 32, KEY_W = 32;
  localparam logic [KEY_W-1:0] KEY_STUB = 32'hC3A5_19E7;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [WIRE_W-1:0] cmd_a = '0, cmd_b = '0, cmd_c = '0;
  logic [MAC_W-1:0] cmd_mac = '0, mac_calc = '0;
  logic rsp_valid, rsp_ok, key_valid;
  logic [CTR_W-1:0] sess_id;
  logic [KEY_W-1:0] key_out;

  always #2 clk = ~clk;

  token_gate_ctrl #(.WIRE_W(WIRE_W), .CTR_W(CTR_W), .MAC_W(MAC_W), .KEY_W(KEY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_c(cmd_c), .cmd_mac(cmd_mac),
    .mac_calc(mac_calc), .key_in(KEY_STUB), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .sess_id(sess_id), .key_valid(key_valid), .key_out(key_out));

  typedef struct {
    logic ok;
    logic [CTR_W-1:0] sid;
    logic kv;
    logic [KEY_W-1:0] key;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  logic [CTR_W-1:0] model_sid = '0;
  logic model_kv = 1'b0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected response ok=%0b, expected none", rsp_ok);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rsp_ok !== e.ok || sess_id !== e.sid || key_valid !== e.kv || key_out !== e.key) begin
          errors++;
          $display("FAIL %s: ok=%0b sid=%0d kv=%0b key=%h, expected ok=%0b sid=%0d kv=%0b key=%h",
                   e.tag, rsp_ok, sess_id, key_valid, key_out, e.ok, e.sid, e.kv, e.key);
        end
      end
    end
  end

  task automatic send(input logic [2:0] op, input logic [WIRE_W-1:0] a,
                      input logic [WIRE_W-1:0] b, input logic [WIRE_W-1:0] c,
                      input logic [MAC_W-1:0] mac, input logic exp_ok, input string tag);
    exp_t e;
    if (op == 3'd0 && exp_ok) begin
      model_sid = model_sid + 1'b1;
      model_kv = 1'b0;
      mac_calc = 32'h1357_9BDF;
    end
    if (op == 3'd4 && exp_ok) model_kv = 1'b1;
    if (exp_ok && (op == 3'd2 || op == 3'd3))
      mac_calc = {mac_calc[MAC_W-2:0], mac_calc[MAC_W-1]} ^ {24'd0, a};
    e.ok = exp_ok; e.sid = model_sid; e.kv = model_kv;
    e.key = model_kv ? KEY_STUB : '0; e.tag = tag;
    exp_q.push_back(e);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b; cmd_c = c; cmd_mac = mac;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic check(input logic cond, input string tag, input int act, input int expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R10 reset rsp", rsp_valid, 0);
    check(key_valid == 1'b0 && key_out == '0, "R9 reset key", key_out, 0);
    check(sess_id == 0, "R1 initial sid", sess_id, 0);
    rst_n = 1'b1;
    @(negedge clk);

    send(3'd2, 8'd5, 0, 0, 0, 1'b0, "R6 gate before start");
    // session A
    send(3'd0, 0, 0, 0, 0, 1'b1, "R1 start A");
    send(3'd1, 8'd2, 8'd3, 8'd2, 0, 1'b1, "R6 header A");
    send(3'd2, 8'd5, 0, 0, 0, 1'b1, "R3 first label X+Y");
    send(3'd2, 8'd7, 0, 0, 0, 1'b1, "R3 skip label");
    send(3'd3, 8'd8, 0, 0, 0, 1'b0, "R5 output beyond last gate");
    send(3'd2, 8'd9, 0, 0, 0, 1'b0, "R4 locked gate");
    // session B
    send(3'd0, 0, 0, 0, 0, 1'b1, "R1 start B");
    send(3'd1, 8'd2, 8'd3, 8'd2, 0, 1'b1, "R6 header B");
    send(3'd3, 8'd4, 0, 0, 0, 1'b1, "R5 output input wire before gates");
    send(3'd3, 8'd0, 0, 0, 0, 1'b1, "R5 output wire 0");
    send(3'd4, 0, 0, 0, mac_calc, 1'b1, "R7 mac match Z outputs no gates");
    check(key_out == KEY_STUB, "R7 key port", key_out, KEY_STUB);
    send(3'd2, 8'd9, 0, 0, 0, 1'b0, "R6 gate after done");
    check(key_valid == 1'b1, "R7 key held after done", key_valid, 1);
    send(3'd0, 0, 0, 0, 0, 1'b1, "R9 start clears key");
    check(key_out == '0, "R9 key zero", key_out, 0);
    // session C
    send(3'd1, 8'd2, 8'd3, 8'd1, 0, 1'b1, "R6 header C");
    send(3'd2, 8'd4, 0, 0, 0, 1'b0, "R3 label below X+Y");
    send(3'd0, 0, 0, 0, 0, 1'b1, "R1 start D");
    send(3'd1, 8'd2, 8'd3, 8'd1, 0, 1'b1, "R6 header D");
    send(3'd2, 8'd6, 0, 0, 0, 1'b1, "R3 gate 6");
    send(3'd2, 8'd6, 0, 0, 0, 1'b0, "R3 repeated label");
    send(3'd4, 0, 0, 0, mac_calc, 1'b0, "R4 mac while locked");
    check(key_out == '0, "R4 no key", key_out, 0);
    send(3'd0, 0, 0, 0, 0, 1'b1, "R1 start E");
    send(3'd1, 8'd1, 8'd1, 8'd1, 0, 1'b1, "R6 header E");
    send(3'd2, 8'd4, 0, 0, 0, 1'b1, "R3 gate 4");
    send(3'd2, 8'd3, 0, 0, 0, 1'b0, "R3 backward label");
    send(3'd0, 0, 0, 0, 0, 1'b1, "R1 start F");
    send(3'd1, 8'd1, 8'd1, 8'd1, 0, 1'b1, "R6 header F");
    send(3'd3, 8'd1, 0, 0, 0, 1'b1, "R5 output server wire");
    send(3'd2, 8'd4, 0, 0, 0, 1'b0, "R6 gate after output");
    send(3'd0, 0, 0, 0, 0, 1'b1, "R1 start G");
    send(3'd1, 8'd1, 8'd1, 8'd1, 0, 1'b1, "R6 header G");
    send(3'd2, 8'd2, 0, 0, 0, 1'b1, "R3 gate 2");
    send(3'd4, 0, 0, 0, mac_calc, 1'b0, "R6 mac before outputs");
    send(3'd0, 0, 0, 0, 0, 1'b1, "R1 start H");
    send(3'd1, 8'd1, 8'd1, 8'd1, 0, 1'b1, "R6 header H");
    send(3'd2, 8'd2, 0, 0, 0, 1'b1, "R3 gate 2 again");
    send(3'd3, 8'd2, 0, 0, 0, 1'b1, "R5 output last gate");
    send(3'd3, 8'd0, 0, 0, 0, 1'b0, "R6 output beyond Z");
    send(3'd0, 0, 0, 0, 0, 1'b1, "R1 start I");
    send(3'd1, 8'd1, 8'd1, 8'd1, 0, 1'b1, "R6 header I");
    send(3'd3, 8'd0, 0, 0, 0, 1'b1, "R5 output I");
    send(3'd4, 0, 0, 0, mac_calc ^ 32'h0000_0100, 1'b0, "R8 mac one bit off");
    check(key_valid == 1'b0 && key_out == '0, "R8 key withheld", key_out, 0);
    send(3'd4, 0, 0, 0, mac_calc, 1'b0, "R4 correct mac after mismatch");
    send(3'd0, 0, 0, 0, 0, 1'b1, "R1 start J");
    send(3'd1, 8'd1, 8'd1, 8'd1, 0, 1'b1, "R6 header J");
    send(3'd1, 8'd1, 8'd1, 8'd1, 0, 1'b0, "R6 second header");
    send(3'd0, 0, 0, 0, 0, 1'b1, "R1 start K");
    send(3'd5, 0, 0, 0, 0, 1'b0, "R6 unknown op");
    // reset keeps counter
    rst_n = 1'b0;
    @(negedge clk);
    check(sess_id == model_sid, "R2 sid across reset", sess_id, model_sid);
    rst_n = 1'b1;
    @(negedge clk);
    check(sess_id == model_sid, "R2 sid after reset", sess_id, model_sid);
    send(3'd1, 8'd1, 8'd1, 8'd1, 0, 1'b0, "R2 header after reset");
    while (model_sid != 4'hF)
      send(3'd0, 0, 0, 0, 0, 1'b1, "R1 start run");
    send(3'd0, 0, 0, 0, 0, 1'b0, "R11 start at ceiling");
    check(sess_id == 4'hF, "R11 counter held", sess_id, 15);
    check(exp_q.size() == 0, "R10 all responses seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule